// File: doc/BRIEF.md
# Tagged Message Buffer Fetcher

This block fills a small pool of message buffers for a sponge-style hashing engine. Each buffer holds 17 words of 64 bits (1088 bits), one message chunk. A context manager hands over a context, meaning a context id and a base address. The fetcher places that context in a free buffer and reads the chunk from memory one 64-bit word at a time. The pool has `min(NUM_CTX, 4)` buffers.

Read requests go out back to back for as long as the memory port accepts them. Each request carries a tag that names the destination buffer and the word slot. The memory may answer in any order, and every response is written to the slot its tag names. Several buffers can have reads in flight at the same time through the one port. Once all 17 words of a buffer have arrived, the buffer is offered to the absorb controller. The buffer stays offered until the controller takes it, and taking it returns the buffer to the free pool.

Top module: `msg_buf_fetcher`

## Requirements
- R1: After reset, `req_valid` and `abs_valid` are low and `ld_ready` is high.
- R2: `ld_ready` is high exactly when at least one buffer is free. An accepted load always occupies the lowest-numbered free buffer. The number of buffers is `min(NUM_CTX, 4)`.
- R3: Each load causes exactly 17 accepted requests for its buffer. Their word indices run 0 to 16 in order, and word w is read from address `base + 8*w`.
- R4: `req_tag` is `{buffer index, word index}`, with the word index in the low 5 bits and the buffer index in the bits above them.
- R5: When several buffers still have words left to request, requests come from the lowest-numbered one. `req_valid` stays high every cycle while any buffer has a word left to request, including cycles in which `req_ready` is low.
- R6: A response with `rsp_valid` high stores `rsp_data` into the buffer and word slot named by `rsp_tag`. Responses may arrive in any order.
- R7: `abs_valid` rises once all 17 words of a buffer have arrived. When more than one buffer is full, the offer shows the lowest-numbered full buffer. `abs_ctx` is that buffer's context id, and bits `[64w+63:64w]` of `abs_data` hold its word w.
- R8: While `abs_valid` is high and `abs_take` is low, `abs_valid` stays high in the next cycle.
- R9: A cycle with both `abs_valid` and `abs_take` high frees the offered buffer, and `ld_ready` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A context is offered for fetching |
| ld_ready | output | 1 | A buffer is free to take the context |
| ld_ctx | input | CW | Context id of the offered context |
| ld_base | input | ADDR_W | Byte base address of the message chunk |
| req_valid | output | 1 | Read request is valid |
| req_ready | input | 1 | Memory port accepts the request |
| req_addr | output | ADDR_W | Byte address of the requested word |
| req_tag | output | BW+5 | Destination buffer and word slot |
| rsp_valid | input | 1 | Read data is valid |
| rsp_tag | input | BW+5 | Tag of the returned word |
| rsp_data | input | 64 | Returned word |
| abs_valid | output | 1 | A full buffer is offered for absorption |
| abs_take | input | 1 | The absorb controller consumes the offered buffer |
| abs_ctx | output | CW | Context id of the offered buffer |
| abs_data | output | 1088 | The 17 words of the offered buffer |

## Verification
The bench builds the block with `NUM_CTX=3` and a 16-bit address. This gives three buffers, so the buffer-index field of the tag has an unused code. The pool also fills with a count that is not a power of two. The bench pushes twelve contexts through the pool. Readiness on the request side follows an irregular pattern, and responses come back from a shuffled pool of outstanding reads. This reaches back-pressure in mid-stream, overlapping fills, full buffers that are held and taken later, and buffers reused after absorption.

// File: rtl/msg_buf_fetcher.sv
module msg_buf_fetcher #(
  parameter int NUM_CTX = 6,
  parameter int ADDR_W  = 32,
  localparam int NB = (NUM_CTX < 4) ? NUM_CTX : 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int CW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int NW = 17,
  localparam int WW = 5,
  localparam int TW = BW + WW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [CW-1:0]     ld_ctx,
  input  logic [ADDR_W-1:0] ld_base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [TW-1:0]     req_tag,
  input  logic              rsp_valid,
  input  logic [TW-1:0]     rsp_tag,
  input  logic [63:0]       rsp_data,
  output logic              abs_valid,
  input  logic              abs_take,
  output logic [CW-1:0]     abs_ctx,
  output logic [NW*64-1:0]  abs_data
);

  logic [NB-1:0]     busy;
  logic [WW-1:0]     cnt  [NB];
  logic [NW-1:0]     mask [NB];
  logic [ADDR_W-1:0] base [NB];
  logic [CW-1:0]     ctx  [NB];
  logic [63:0]       mem  [NB][NW];

  logic [BW-1:0] ld_sel, rq_sel, ab_sel;
  logic          rq_any, ab_any;
  logic [BW-1:0] rb;
  logic [WW-1:0] rw;

  assign rb = rsp_tag[TW-1:WW];
  assign rw = rsp_tag[WW-1:0];

  always_comb begin
    ld_sel = '0;
    rq_sel = '0;
    ab_sel = '0;
    rq_any = 1'b0;
    ab_any = 1'b0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (!busy[b]) ld_sel = BW'(b);
      if (busy[b] && cnt[b] != WW'(NW)) begin
        rq_sel = BW'(b);
        rq_any = 1'b1;
      end
      if (busy[b] && &mask[b]) begin
        ab_sel = BW'(b);
        ab_any = 1'b1;
      end
    end
  end

  assign ld_ready  = ~&busy;
  assign req_valid = rq_any;
  assign req_tag   = {rq_sel, cnt[rq_sel]};
  assign req_addr  = base[rq_sel] + ADDR_W'({cnt[rq_sel], 3'b000});
  assign abs_valid = ab_any;
  assign abs_ctx   = ctx[ab_sel];

  always_comb begin
    for (int w = 0; w < NW; w++) abs_data[64*w +: 64] = mem[ab_sel][w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      for (int b = 0; b < NB; b++) begin
        cnt[b]  <= '0;
        mask[b] <= '0;
        base[b] <= '0;
        ctx[b]  <= '0;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (ld_valid && ld_ready && ld_sel == BW'(b)) begin
          busy[b] <= 1'b1;
          cnt[b]  <= '0;
          mask[b] <= '0;
          base[b] <= ld_base;
          ctx[b]  <= ld_ctx;
        end else begin
          if (req_valid && req_ready && rq_sel == BW'(b)) cnt[b] <= cnt[b] + 1'b1;
          if (rsp_valid && rb == BW'(b)) mask[b][rw] <= 1'b1;
          if (abs_valid && abs_take && ab_sel == BW'(b)) busy[b] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid) mem[rb][rw] <= rsp_data;
  end

  a_r6_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (int'(rb) < NB) && busy[rb] && (rw < cnt[rb]) && !mask[rb][rw]);

  a_r5_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);

  a_r8_abs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    abs_valid && !abs_take |=> abs_valid);

  a_r9_free_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    abs_valid && abs_take |=> ld_ready);

endmodule

// File: tb/msg_buf_fetcher_tb.sv
module msg_buf_fetcher_tb_top;
  localparam int NCTX = 3, AW = 16, NB = 3, BW = 2, CW = 2, TW = 7, NW = 17;
  localparam int NLOAD = 12;

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_ready;
  logic [CW-1:0] ld_ctx = '0;
  logic [AW-1:0] ld_base = '0;
  logic req_valid, req_ready = 0;
  logic [AW-1:0] req_addr;
  logic [TW-1:0] req_tag;
  logic rsp_valid = 0;
  logic [TW-1:0] rsp_tag = '0;
  logic [63:0] rsp_data = '0;
  logic abs_valid, abs_take = 0;
  logic [CW-1:0] abs_ctx;
  logic [NW*64-1:0] abs_data;

  always #5 clk = ~clk;

  msg_buf_fetcher #(.NUM_CTX(NCTX), .ADDR_W(AW)) dut_i (.*);

  int tests = 0, fails = 0;

  function automatic logic [63:0] word_of(input logic [AW-1:0] a);
    return {a, ~a, a ^ 16'hA5C3, a + 16'h1234};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  bit mbusy [NB];
  int miss [NB], mrcv [NB];
  logic [AW-1:0] mbase [NB];
  logic [CW-1:0] mctx [NB];
  logic [TW-1:0] ptag [64];
  logic [AW-1:0] paddr [64];
  int pn = 0;
  int loaded = 0, absorbed = 0;
  int unsigned lcg = 32'h1234_5678;
  bit done = 0;

  function automatic int lowest_free();
    for (int b = 0; b < NB; b++) if (!mbusy[b]) return b;
    return -1;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ld_ready === 1'b1, "R1 ld_ready after reset", 64'(ld_ready), 64'd1);
    chk(req_valid === 1'b0, "R1 req_valid after reset", 64'(req_valid), 64'd0);
    chk(abs_valid === 1'b0, "R1 abs_valid after reset", 64'(abs_valid), 64'd0);
    rst_n = 1;
    for (int cyc = 0; cyc < 20000 && absorbed < NLOAD; cyc++) begin
      int ps, ib, fb, lf;
      bit rfire, afire, lfire;
      @(negedge clk);
      lcg = lcg * 32'd1103515245 + 32'd12345;
      req_ready = (lcg[20:18] != 3'd0) && (lcg[23:21] != 3'd1);
      rsp_valid = 0;
      if (pn > 0 && (lcg[9] || pn >= 10 || loaded == NLOAD)) begin
        ps = int'(lcg[31:16]) % pn;
        rsp_valid = 1;
        rsp_tag = ptag[ps];
        rsp_data = word_of(paddr[ps]);
        ptag[ps] = ptag[pn-1];
        paddr[ps] = paddr[pn-1];
        pn--;
      end
      lf = lowest_free();
      ld_valid = (loaded < NLOAD) && lcg[5];
      ld_base = AW'(16'h0100 * loaded + 16'h0048);
      ld_ctx = CW'(loaded % NCTX);
      #1;
      chk(ld_ready === (lf >= 0), "R2/R9 ld_ready vs free buffers", 64'(ld_ready), 64'(lf >= 0));
      ib = -1;
      for (int b = NB - 1; b >= 0; b--) if (mbusy[b] && miss[b] < NW) ib = b;
      chk(req_valid === (ib >= 0), "R5 req_valid while words pending", 64'(req_valid), 64'(ib >= 0));
      rfire = 0;
      if (ib >= 0 && req_valid) begin
        chk(req_tag === {BW'(ib), 5'(miss[ib])}, "R4/R5 req_tag", 64'(req_tag), 64'({BW'(ib), 5'(miss[ib])}));
        chk(req_addr === AW'(mbase[ib] + 8 * miss[ib]), "R3 req_addr", 64'(req_addr), 64'(AW'(mbase[ib] + 8 * miss[ib])));
        rfire = req_ready;
      end
      fb = -1;
      for (int b = NB - 1; b >= 0; b--) if (mbusy[b] && mrcv[b] == NW) fb = b;
      chk(abs_valid === (fb >= 0), "R7/R8 abs_valid", 64'(abs_valid), 64'(fb >= 0));
      afire = 0;
      if (fb >= 0 && abs_valid) begin
        chk(abs_ctx === mctx[fb], "R7 abs_ctx", 64'(abs_ctx), 64'(mctx[fb]));
        for (int w = 0; w < NW; w++)
          chk(abs_data[64*w +: 64] === word_of(AW'(mbase[fb] + 8 * w)), "R6/R7 abs_data word",
              abs_data[64*w +: 64], word_of(AW'(mbase[fb] + 8 * w)));
        afire = lcg[13];
      end
      abs_take = afire;
      lfire = ld_valid && (lf >= 0);
      if (rsp_valid) mrcv[int'(rsp_tag[TW-1:5])]++;
      if (rfire) begin
        ptag[pn] = req_tag;
        paddr[pn] = req_addr;
        pn++;
        miss[ib]++;
      end
      if (afire) begin
        mbusy[fb] = 0;
        absorbed++;
      end
      if (lfire) begin
        mbusy[lf] = 1; miss[lf] = 0; mrcv[lf] = 0;
        mbase[lf] = ld_base; mctx[lf] = ld_ctx;
        loaded++;
      end
    end
    @(negedge clk);
    abs_take = 0; rsp_valid = 0; ld_valid = 0;
    chk(absorbed == NLOAD, "R3/R9 all contexts absorbed", 64'(absorbed), 64'(NLOAD));
    #1;
    chk(req_valid === 1'b0 && abs_valid === 1'b0, "R3 idle after drain", 64'({req_valid, abs_valid}), 64'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule